// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block lets a clocked system read and write an external asynchronous static RAM of 8192 bytes. A host raises a request together with an address, a read/write select and write data, and holds them until the controller pulses a one-cycle acknowledge. The controller latches the request and then runs the memory strobes. These are an active-low select, an active-high select, an active-low output enable and an active-low write enable. It also drives the byte-wide data bus through a separate drive-enable.

Every phase of a memory cycle lasts a whole number of clock cycles. The count is derived from nanosecond minimums and the clock period, all of which are parameters. Write data is presented before the write strobe falls and held past its rising edge, which is the edge that ends the write. A read waits for the longest of the access, cycle and output-enable delays before it samples the bus. After a read, the controller keeps its drivers off until the memory's output turn-off time has passed.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and while idle: `mem_sel_n_o`=1, `mem_sel_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0 and `ack_o`=0.
- R2: `mem_we_n_o` is low only while `mem_sel_n_o`=0, `mem_sel_o`=1 and `mem_oe_n_o`=1. It stays low for at least max(ceil(T_PWE_NS/P), ceil(T_SD_NS/P)) cycles, where P is CLK_PERIOD_NS.
- R3: During a write, `mem_dq_o` is driven and unchanged for at least ceil(T_SD_NS/P) cycles before `mem_we_n_o` rises, and for at least one cycle after it. `mem_addr_o` does not change while the memory is selected.
- R4: A write accepted from idle is acknowledged 1+S+W+H clock edges after the edge that accepts it. S, W and H are the phase lengths. H is stretched so that S+W+H covers ceil(T_WC_NS/P).
- R5: A read holds select active, `mem_oe_n_o`=0 and `mem_we_n_o`=1 for A = ceil(max(T_RC_NS,T_AA_NS,T_DOE_NS)/P) cycles. It then samples `mem_dq_i`. A read accepted from idle is acknowledged A+1 edges after acceptance, and `rdata_o` then holds the addressed byte.
- R6: `ack_o` lasts exactly one cycle, and `rdata_o` keeps its value after the acknowledge.
- R7: `mem_dq_oe_o` is high only while `mem_oe_n_o` is high. After the output enable rises at the end of a read, the data bus stays undriven for at least ceil(T_HZOE_NS/P) cycles.
- R8: Address and write data are latched when a request is accepted. Changes on `addr_i` and `wdata_i` after acceptance have no effect on that cycle.
- R9: A phase whose minimum is 0 ns still lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data |
| mem_addr_o | output | 13 | Memory address lines |
| mem_sel_n_o | output | 1 | Active-low memory select |
| mem_sel_o | output | 1 | Active-high memory select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data received from the memory |

## Verification
The bench builds the controller with a 20 ns period and these minimums: write pulse 45 ns, data setup 30 ns, address setup 0 ns, address hold 5 ns, write cycle 120 ns, read cycle 40 ns, access 55 ns, output-enable access 25 ns and turn-off 30 ns. This gives a 3-cycle write pulse. The hold phase is stretched to 2 cycles by the write cycle time, and the zero-nanosecond setup rounds up to one cycle. The read access lasts 3 cycles and the turnaround 2 cycles. With these settings a premature sample, a truncated pulse or an early bus drive each shows up in the memory model at a distinct cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } state_e;

  // ceil(ns/per), never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SETUP_C = 1,
  parameter int unsigned PULSE_C = 1,
  parameter int unsigned HOLD_C  = 1,
  parameter int unsigned ACC_C   = 1,
  parameter int unsigned TURN_C  = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  state_e state_d_i,
  output logic   done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;

  always_comb begin
    unique case (state_d_i)
      ST_RD_ACC:   len_m1 = CNT_W'(ACC_C - 1);
      ST_WR_SETUP: len_m1 = CNT_W'(SETUP_C - 1);
      ST_WR_PULSE: len_m1 = CNT_W'(PULSE_C - 1);
      ST_WR_HOLD:  len_m1 = CNT_W'(HOLD_C - 1);
      ST_TURN:     len_m1 = CNT_W'(TURN_C - 1);
      default:     len_m1 = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_m1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  input  logic   done_i,
  output state_e state_q_o,
  output state_e state_d_o,
  output logic   accept_o,
  output logic   capture_o,
  output logic   ack_o
);

  state_e state_q, state_d;
  logic   ack_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i && !ack_q) state_d = we_i ? ST_WR_SETUP : ST_RD_ACC;
      ST_RD_ACC:   if (done_i) state_d = ST_RD_CAP;
      ST_RD_CAP:   state_d = ST_TURN;
      ST_TURN:     if (done_i) state_d = ST_IDLE;
      ST_WR_SETUP: if (done_i) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (done_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (done_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign accept_o  = (state_q == ST_IDLE) && (state_d != ST_IDLE);
  assign capture_o = (state_q == ST_RD_ACC) && (state_d == ST_RD_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= capture_o || ((state_q == ST_WR_HOLD) && (state_d == ST_IDLE));
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign ack_o     = ack_q;

  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);

  // R5
  rd_ack_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && !(state_q == ST_IDLE)) |-> (state_q == ST_RD_CAP));

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_n_o,
  output logic              sel_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              nxt_sel, nxt_rd, nxt_wr, nxt_drv;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign nxt_rd  = (state_d_i == ST_RD_ACC);
  assign nxt_wr  = (state_d_i == ST_WR_PULSE);
  assign nxt_drv = (state_d_i == ST_WR_SETUP) || (state_d_i == ST_WR_PULSE) ||
                   (state_d_i == ST_WR_HOLD);
  assign nxt_sel = nxt_rd || nxt_drv;

  // strobes registered from next state: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_n_o <= 1'b1;
      sel_o   <= 1'b0;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      sel_n_o <= !nxt_sel;
      sel_o   <= nxt_sel;
      oe_n_o  <= !nxt_rd;
      we_n_o  <= !nxt_wr;
      dq_oe_o <= nxt_drv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  // R2
  we_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (!sel_n_o && sel_o && oe_n_o));

  // R7
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_n_o);

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_o && $past(!sel_n_o)) |-> $stable(addr_o));

  // R3
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o)) |-> $stable(dq_o));

  // R3
  we_rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (dq_oe_o && !sel_n_o));

  // R1
  sel_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o == !sel_n_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_RC_NS       = 20,
  parameter int unsigned T_AA_NS       = 20,
  parameter int unsigned T_DOE_NS      = 8,
  parameter int unsigned T_HZOE_NS     = 8,
  parameter int unsigned T_WC_NS       = 20,
  parameter int unsigned T_PWE_NS      = 15,
  parameter int unsigned T_SD_NS       = 10,
  parameter int unsigned T_SA_NS       = 0,
  parameter int unsigned T_HA_NS       = 0,
  parameter int unsigned T_HD_NS       = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sel_n_o,
  output logic              mem_sel_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned P        = CLK_PERIOD_NS;
  localparam int unsigned SETUP_C  = ns_to_cyc(T_SA_NS, P);
  localparam int unsigned PULSE_C  = max2(ns_to_cyc(T_PWE_NS, P), ns_to_cyc(T_SD_NS, P));
  localparam int unsigned HOLD_MIN = max2(ns_to_cyc(T_HA_NS, P), ns_to_cyc(T_HD_NS, P));
  localparam int unsigned WC_C     = ns_to_cyc(T_WC_NS, P);
  localparam int unsigned HOLD_C   = (WC_C > SETUP_C + PULSE_C + HOLD_MIN) ?
                                     (WC_C - SETUP_C - PULSE_C) : HOLD_MIN;
  localparam int unsigned ACC_C    = max2(max2(ns_to_cyc(T_RC_NS, P), ns_to_cyc(T_AA_NS, P)),
                                          ns_to_cyc(T_DOE_NS, P));
  localparam int unsigned TURN_C   = ns_to_cyc(T_HZOE_NS, P);
  localparam int unsigned MAX_C    = max2(max2(max2(SETUP_C, PULSE_C), max2(HOLD_C, ACC_C)),
                                          TURN_C);
  localparam int unsigned CNT_W    = $clog2(MAX_C + 1);

  state_e state_q, state_d;
  logic   done, accept, capture;

  sram_ctrl_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .done_i    (done),
    .state_q_o (state_q),
    .state_d_o (state_d),
    .accept_o  (accept),
    .capture_o (capture),
    .ack_o     (ack_o)
  );

  sram_ctrl_timer #(
    .CNT_W   (CNT_W),
    .SETUP_C (SETUP_C),
    .PULSE_C (PULSE_C),
    .HOLD_C  (HOLD_C),
    .ACC_C   (ACC_C),
    .TURN_C  (TURN_C)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_d != state_q),
    .state_d_i (state_d),
    .done_o    (done)
  );

  sram_ctrl_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .sel_n_o   (mem_sel_n_o),
    .sel_o     (mem_sel_o),
    .oe_n_o    (mem_oe_n_o),
    .we_n_o    (mem_we_n_o),
    .dq_o      (mem_dq_o),
    .dq_oe_o   (mem_dq_oe_o),
    .rdata_o   (rdata_o)
  );

  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (mem_sel_n_o && !mem_sel_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int PER  = 20;
  localparam int AW   = 13;
  localparam int DW   = 8;
  localparam int DEPTH = 1 << AW;
  localparam int RC = 40, AA = 55, DOE = 25, HZOE = 30;
  localparam int WC = 120, PWE = 45, SD = 30, SA = 0, HA = 5;

  function automatic int cyc(int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SA_E   = cyc(SA);
  localparam int PW_E   = (cyc(PWE) > cyc(SD)) ? cyc(PWE) : cyc(SD);
  localparam int SD_E   = cyc(SD);
  localparam int HM_E   = cyc(HA);
  localparam int HO_E   = (cyc(WC) > SA_E + PW_E + HM_E) ? cyc(WC) - SA_E - PW_E : HM_E;
  localparam int ACC_E  = (cyc(RC) > cyc(AA) ? (cyc(RC) > cyc(DOE) ? cyc(RC) : cyc(DOE))
                                             : (cyc(AA) > cyc(DOE) ? cyc(AA) : cyc(DOE)));
  localparam int HZ_E   = cyc(HZOE);
  localparam int WLAT_E = 1 + SA_E + PW_E + HO_E;
  localparam int RLAT_E = 1 + ACC_E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic          m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe;
  logic [DW-1:0] m_dq_o;
  logic [DW-1:0] m_dq_i = '0;

  always #10 clk = ~clk;

  sram_ctrl #(
    .CLK_PERIOD_NS (PER), .T_RC_NS (RC), .T_AA_NS (AA), .T_DOE_NS (DOE),
    .T_HZOE_NS (HZOE), .T_WC_NS (WC), .T_PWE_NS (PWE), .T_SD_NS (SD),
    .T_SA_NS (SA), .T_HA_NS (HA), .T_HD_NS (0)
  ) u_sram_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .ack_o (ack), .rdata_o (rdata), .mem_addr_o (m_addr),
    .mem_sel_n_o (m_sel_n), .mem_sel_o (m_sel), .mem_oe_n_o (m_oe_n),
    .mem_we_n_o (m_we_n), .mem_dq_o (m_dq_o), .mem_dq_oe_o (m_dq_oe),
    .mem_dq_i (m_dq_i)
  );

  int vec = 0, bad = 0;
  bit ended = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  // memory model: strobe legality, pulse width, setup/hold, contention
  bit            p_wr = 0, p_rd = 0, p_dq_oe = 0;
  int            wlen = 0, rcnt = 0, hz_left = 0, dstab = 0, p_dstab = 0;
  logic [DW-1:0] p_dq = '0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    bit sel, wr, rd;
    if (rst_n) begin
      sel = !m_sel_n && m_sel;
      wr  = sel && !m_we_n;
      rd  = sel && !m_oe_n && m_we_n;
      if (!m_we_n) chk(sel && m_oe_n, "R2 write strobe combination", {m_sel_n, m_sel, m_oe_n}, 3'b011);
      if (!m_oe_n) chk(sel && m_we_n, "R5 read strobe combination", {m_sel_n, m_sel, m_we_n}, 3'b011);
      if (m_dq_oe) chk(m_oe_n && hz_left == 0, "R7 bus contention", hz_left, 0);
      p_dstab = dstab;
      if (m_dq_oe) dstab = (p_dq_oe && m_dq_o == p_dq) ? dstab + 1 : 1;
      else dstab = 0;
      if (wr) begin
        wlen = p_wr ? wlen + 1 : 1;
        if (p_wr) chk(m_addr == p_addr, "R3 address moved in write", m_addr, p_addr);
      end
      if (p_wr && !wr) begin
        chk(wlen >= PW_E, "R2 write pulse width", wlen, PW_E);
        chk(p_dstab >= SD_E, "R3 data setup", p_dstab, SD_E);
        chk(m_dq_oe && m_dq_o == p_dq && m_addr == p_addr, "R3 data hold", m_dq_o, p_dq);
        mem[p_addr] = p_dq;
      end
      if (rd) rcnt = (p_rd && m_addr == p_addr) ? rcnt + 1 : 1;
      if (hz_left > 0) hz_left--;
      if (p_rd && !rd) hz_left = HZ_E;
      if (rd) m_dq_i = (rcnt >= ACC_E) ? mem[m_addr] : ~mem[m_addr];
      else if (hz_left == 0) m_dq_i = '0;
      p_wr = wr; p_rd = rd; p_dq_oe = m_dq_oe; p_dq = m_dq_o; p_addr = m_addr;
    end
  end

  task automatic idle_chk(input string tag);
    chk(m_sel_n && !m_sel && m_oe_n && m_we_n && !m_dq_oe && !ack, tag,
        {m_sel_n, m_sel, m_oe_n, m_we_n, m_dq_oe, ack}, 6'b101100);
  endtask

  task automatic txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit timed, input bit scramble);
    int n;
    bit got;
    logic [DW-1:0] r;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    n = 0; got = 0;
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      if (ack) got = 1;
      else if (scramble && n == 1) begin
        addr = ~a; wdata = ~d; we = w;
      end
    end
    req = 1'b0;
    if (!got) begin
      chk(0, "R6 transaction timeout", n, 0);
      finish_run();
    end
    if (timed) begin
      if (w) chk(n == WLAT_E, "R4 R9 write latency", n, WLAT_E);
      else   chk(n == RLAT_E, "R5 read latency", n, RLAT_E);
    end
    if (!w) begin
      chk(rdata == ref_mem[a], scramble ? "R8 read with input change" : "R5 read data",
          rdata, ref_mem[a]);
      r = rdata;
    end else begin
      ref_mem[a] = d;
    end
    @(negedge clk);
    chk(!ack, "R6 ack width", ack, 0);
    if (!w) chk(rdata == r, "R6 rdata hold", rdata, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed1234);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = DW'((i * 37 + 11) ^ (i >> 5));
      ref_mem[i] = DW'((i * 37 + 11) ^ (i >> 5));
    end
    repeat (3) @(negedge clk);
    idle_chk("R1 pins in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_chk("R1 pins idle after reset");

    // directed corners: address ends, timing, input change after accept
    txn(1, 13'h0000, 8'hA5, 1, 0);
    repeat (4) @(negedge clk);
    txn(1, 13'h1FFF, 8'h5A, 1, 0);
    repeat (4) @(negedge clk);
    idle_chk("R1 idle between cycles");
    txn(0, 13'h0000, 8'h00, 1, 0);
    repeat (4) @(negedge clk);
    txn(0, 13'h1FFF, 8'h00, 1, 0);
    repeat (4) @(negedge clk);
    txn(1, 13'h0064, 8'h3C, 1, 1);
    repeat (4) @(negedge clk);
    txn(0, 13'h0064, 8'h00, 1, 1);
    // back-to-back: write->read, read->write turnaround, write->write
    txn(1, 13'h0101, 8'hFF, 0, 0);
    txn(0, 13'h0101, 8'h00, 0, 0);
    txn(1, 13'h0102, 8'h00, 0, 0);
    txn(1, 13'h0103, 8'h81, 0, 0);
    txn(0, 13'h0102, 8'h00, 0, 0);
    txn(0, 13'h0103, 8'h00, 0, 0);

    for (int k = 0; k < 1500; k++) begin
      bit w, tm;
      logic [AW-1:0] a;
      int gap;
      w   = ($urandom % 2) == 1;
      a   = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 64);
      tm  = (k % 8) == 0;
      gap = tm ? 4 : int'($urandom % 3);
      repeat (gap) @(negedge clk);
      txn(w, a, DW'($urandom), tm, 0);
    end
    repeat (6) @(negedge clk);
    idle_chk("R1 idle at end");
    finish_run();
  end

endmodule